// File: doc/BRIEF.md
# Dual-Side Byte Mailbox

Two processors share this mailbox to pass short messages: a management side and a host side. Each side has its own register port with a word-aligned byte address. Behind the ports sit sixteen shared one-byte data registers at a four-byte stride. Each side also has its own bank of change flags and its own interrupt-enable bits. There is one control register for each side, holding a doorbell, a receive flag and an interrupt mask.

A sender fills some data registers and then rings its doorbell. This raises the peer's receive flag and, unless the peer has masked it, the peer's interrupt. The receiver can mask the interrupt while it works, leaving the flag up. After it has read the bytes, one control write clears the flag and unmasks the interrupt again. Every data write also marks the matching change flag on the peer's side, and each such flag can raise an interrupt of its own.

Top module: `byte_mailbox`

## Requirements
- R1: Data register i (0..15) sits at byte offset 4*i on both ports. A write from either side stores the byte, and a read from either side returns it in rdata[7:0] with rdata[31:8] = 0.
- R2: A data write to register i sets bit i of the other side's change flags and leaves the writer's own flags alone. Each side reads its own flags 0..7 at 0x40 and 8..15 at 0x44, one bit per register in bit order.
- R3: Writing 1 to a change-flag bit clears it, and writing 0 leaves it unchanged. If the peer writes that data register in the same cycle, the bit ends up set.
- R4: Each side's per-register interrupt enables are read/write at 0x50 (registers 0..7) and 0x54 (registers 8..15), one bit per register.
- R5: The control byte has the receive flag in bit 7, the mask in bit 1 and the doorbell in bit 0. A side that writes its control byte with bit 0 set raises the other side's receive flag. Bit 0 always reads 0.
- R6: In a control write, bit 7 = 1 clears the writer's own receive flag, and the mask takes the value of bit 1. So 0x80 clears the flag and unmasks, while 0x02 masks and leaves the flag as it was.
- R7: If the peer rings in the same cycle as a side's own clear write, the receive flag ends up set.
- R8: A side's interrupt is high exactly when (its receive flag is 1 and its mask is 0) or some change-flag bit and its enable are both 1.
- R9: The management control byte is at 0x48 and the host control byte at 0x4C. Both can be read from either port. Each side can write only its own, and a write to the other side's byte has no effect.
- R10: If both sides write the same data register in one cycle, the management byte is stored and both sides' change flags for it are set.
- R11: After reset every data byte, flag, enable, mask and interrupt is 0.
- R12: A read of an unmapped offset (0x58 and up), or with select low, returns 0. A write to an unmapped offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| m_sel_i | input | 1 | Management port select |
| m_wr_i | input | 1 | Management write strobe (read when low) |
| m_addr_i | input | 7 | Management byte address |
| m_wdata_i | input | 8 | Management write byte |
| m_rdata_o | output | 32 | Management read word, combinational |
| m_irq_o | output | 1 | Interrupt toward the management side |
| h_sel_i | input | 1 | Host port select |
| h_wr_i | input | 1 | Host write strobe (read when low) |
| h_addr_i | input | 7 | Host byte address |
| h_wdata_i | input | 8 | Host write byte |
| h_rdata_o | output | 32 | Host read word, combinational |
| h_irq_o | output | 1 | Interrupt toward the host side |

## Verification
The data path is tested with a distinct byte in every register, written from one side and read from both. This catches swapped stride decoding or a missing bank. The doorbell runs through ring, mask and acknowledge with each of the codes 0x01, 0x02 and 0x80. This shows that the flag and the mask move independently. Same-cycle patterns are driven on both ports at once: ring against acknowledge, data against data, and data against a flag clear. These tell set-over-clear and management priority apart from the opposite orderings. A write to the foreign control byte and a write to an unmapped offset are each followed by reads that would show any stray update.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // control byte bit positions (software decodes these)
    localparam int CTL_RECV = 7;
    localparam int CTL_MASK = 1;
    localparam int CTL_SEND = 0;

    localparam int SIDE_MGMT = 0;
    localparam int SIDE_HOST = 1;

    function automatic logic [7:0] ctl_byte(input logic recv, input logic mask);
        logic [7:0] b;
        b           = '0;
        b[CTL_RECV] = recv;
        b[CTL_MASK] = mask;
        return b;
    endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode #(
    parameter int NREG  = 16,
    parameter int NBANK = 2,
    parameter int AW    = 7,
    parameter int SIDE  = 0
) (
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    output logic [NREG-1:0]  data_we_o,
    output logic [NBANK-1:0] stat_we_o,
    output logic [NBANK-1:0] ien_we_o,
    output logic             ctl_we_o
);
    localparam int IW       = AW - 2;
    localparam int STAT_IDX = NREG;
    localparam int CTL_IDX  = NREG + NBANK;
    localparam int IEN_IDX  = NREG + NBANK + 2;

    logic [IW-1:0] idx;
    logic          wen;

    assign idx = addr_i[AW-1:2];
    assign wen = sel_i & wr_i;

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            data_we_o[i] = wen && (idx == IW'(i));
        end
        for (int b = 0; b < NBANK; b++) begin
            stat_we_o[b] = wen && (idx == IW'(STAT_IDX + b));
            ien_we_o[b]  = wen && (idx == IW'(IEN_IDX + b));
        end
        // only this side's own control word is writable from here
        ctl_we_o = wen && (idx == IW'(CTL_IDX + SIDE));
    end

endmodule

// File: rtl/mbox_data.sv
module mbox_data #(
    parameter int NREG = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NREG-1:0]      m_we_i,
    input  logic [7:0]           m_wdata_i,
    input  logic [NREG-1:0]      h_we_i,
    input  logic [7:0]           h_wdata_i,
    output logic [NREG-1:0][7:0] data_o
);
    logic [NREG-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < NREG; i++) begin
            if (h_we_i[i]) mem_d[i] = h_wdata_i;
            // management side applied last: it wins a collision
            if (m_we_i[i]) mem_d[i] = m_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) mem_q <= '0;
        else         mem_q <= mem_d;
    end

    assign data_o = mem_q;

endmodule

// File: rtl/mbox_side.sv
module mbox_side #(
    parameter int NREG  = 16,
    parameter int NBANK = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctl_we_i,
    input  logic [NBANK-1:0] stat_we_i,
    input  logic [NBANK-1:0] ien_we_i,
    input  logic [7:0]       wdata_i,
    input  logic             peer_send_i,
    input  logic [NREG-1:0]  stat_set_i,
    output logic             send_o,
    output logic             recv_o,
    output logic             mask_o,
    output logic [NREG-1:0]  stat_o,
    output logic [NREG-1:0]  ien_o,
    output logic             irq_o
);
    import mbox_pkg::*;

    typedef struct packed {
        logic            recv;
        logic            mask;
        logic [NREG-1:0] stat;
        logic [NREG-1:0] ien;
    } side_st_t;

    side_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // control write: clear-on-one flag, mask follows the written bit
        if (ctl_we_i) begin
            if (wdata_i[CTL_RECV]) st_d.recv = 1'b0;
            st_d.mask = wdata_i[CTL_MASK];
        end
        // a doorbell from the peer overrides a same-cycle clear
        if (peer_send_i) st_d.recv = 1'b1;
        for (int b = 0; b < NBANK; b++) begin
            if (stat_we_i[b]) st_d.stat[b*8 +: 8] = st_q.stat[b*8 +: 8] & ~wdata_i;
            if (ien_we_i[b])  st_d.ien[b*8 +: 8]  = wdata_i;
        end
        // set after clear: a peer data write is never lost
        st_d.stat = st_d.stat | stat_set_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign send_o = ctl_we_i & wdata_i[CTL_SEND];
    assign recv_o = st_q.recv;
    assign mask_o = st_q.mask;
    assign stat_o = st_q.stat;
    assign ien_o  = st_q.ien;
    assign irq_o  = (st_q.recv & ~st_q.mask) | (|(st_q.stat & st_q.ien));

endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox #(
    parameter  int NREG  = 16,
    localparam int NBANK = NREG / 8,
    localparam int AW    = $clog2((NREG + 2 * NBANK + 2) * 4)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          m_sel_i,
    input  logic          m_wr_i,
    input  logic [AW-1:0] m_addr_i,
    input  logic [7:0]    m_wdata_i,
    output logic [31:0]   m_rdata_o,
    output logic          m_irq_o,
    input  logic          h_sel_i,
    input  logic          h_wr_i,
    input  logic [AW-1:0] h_addr_i,
    input  logic [7:0]    h_wdata_i,
    output logic [31:0]   h_rdata_o,
    output logic          h_irq_o
);
    import mbox_pkg::*;

    localparam int IW       = AW - 2;
    localparam int DW       = $clog2(NREG);
    localparam int STAT_IDX = NREG;
    localparam int CTL_IDX  = NREG + NBANK;
    localparam int IEN_IDX  = NREG + NBANK + 2;

    logic [1:0]                 sel_w, wr_w;
    logic [1:0][AW-1:0]         addr_w;
    logic [1:0][7:0]            wdata_w, rdata_w;
    logic [1:0][NREG-1:0]       data_we_w, stat_w, ien_w;
    logic [1:0][NBANK-1:0]      stat_we_w, ien_we_w;
    logic [1:0]                 ctl_we_w, send_w, recv_w, mask_w, irq_w;
    logic [NREG-1:0][7:0]       data_w;

    assign sel_w   = {h_sel_i, m_sel_i};
    assign wr_w    = {h_wr_i, m_wr_i};
    assign addr_w  = {h_addr_i, m_addr_i};
    assign wdata_w = {h_wdata_i, m_wdata_i};

    mbox_data #(.NREG(NREG)) u_data (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .m_we_i    (data_we_w[SIDE_MGMT]),
        .m_wdata_i (m_wdata_i),
        .h_we_i    (data_we_w[SIDE_HOST]),
        .h_wdata_i (h_wdata_i),
        .data_o    (data_w)
    );

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic [IW-1:0] idx;

        mbox_decode #(.NREG(NREG), .NBANK(NBANK), .AW(AW), .SIDE(s)) u_dec (
            .sel_i     (sel_w[s]),
            .wr_i      (wr_w[s]),
            .addr_i    (addr_w[s]),
            .data_we_o (data_we_w[s]),
            .stat_we_o (stat_we_w[s]),
            .ien_we_o  (ien_we_w[s]),
            .ctl_we_o  (ctl_we_w[s])
        );

        mbox_side #(.NREG(NREG), .NBANK(NBANK)) u_side (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .ctl_we_i    (ctl_we_w[s]),
            .stat_we_i   (stat_we_w[s]),
            .ien_we_i    (ien_we_w[s]),
            .wdata_i     (wdata_w[s]),
            .peer_send_i (send_w[1-s]),
            .stat_set_i  (data_we_w[1-s]),
            .send_o      (send_w[s]),
            .recv_o      (recv_w[s]),
            .mask_o      (mask_w[s]),
            .stat_o      (stat_w[s]),
            .ien_o       (ien_w[s]),
            .irq_o       (irq_w[s])
        );

        assign idx = addr_w[s][AW-1:2];

        always_comb begin
            rdata_w[s] = '0;
            if (sel_w[s]) begin
                if (idx < IW'(NREG)) rdata_w[s] = data_w[idx[DW-1:0]];
                for (int b = 0; b < NBANK; b++) begin
                    if (idx == IW'(STAT_IDX + b)) rdata_w[s] = stat_w[s][b*8 +: 8];
                    if (idx == IW'(IEN_IDX + b))  rdata_w[s] = ien_w[s][b*8 +: 8];
                end
                if (idx == IW'(CTL_IDX))     rdata_w[s] = ctl_byte(recv_w[SIDE_MGMT], mask_w[SIDE_MGMT]);
                if (idx == IW'(CTL_IDX + 1)) rdata_w[s] = ctl_byte(recv_w[SIDE_HOST], mask_w[SIDE_HOST]);
            end
        end
    end

    assign m_rdata_o = {24'b0, rdata_w[SIDE_MGMT]};
    assign h_rdata_o = {24'b0, rdata_w[SIDE_HOST]};
    assign m_irq_o   = irq_w[SIDE_MGMT];
    assign h_irq_o   = irq_w[SIDE_HOST];

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
    parameter int NREG = 16,
    parameter int AW   = 7
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            m_sel,
    input logic            m_wr,
    input logic [AW-1:0]   m_addr,
    input logic [7:0]      m_wdata,
    input logic            h_sel,
    input logic            h_wr,
    input logic [AW-1:0]   h_addr,
    input logic [7:0]      h_wdata,
    input logic            m_recv,
    input logic            m_mask,
    input logic            h_recv,
    input logic            h_mask,
    input logic [NREG-1:0] m_stat,
    input logic [NREG-1:0] m_ien,
    input logic [NREG-1:0] h_stat,
    input logic [NREG-1:0] h_ien,
    input logic            m_irq,
    input logic            h_irq
);
    localparam int NBANK = NREG / 8;
    localparam int IW    = AW - 2;
    localparam int DW    = $clog2(NREG);
    localparam int CTL_M = NREG + NBANK;
    localparam int CTL_H = NREG + NBANK + 1;

    logic [IW-1:0] m_idx, h_idx;
    logic [DW-1:0] h_reg;
    logic          m_cw, h_cw, h_data_w;

    assign m_idx    = m_addr[AW-1:2];
    assign h_idx    = h_addr[AW-1:2];
    assign h_reg    = h_addr[DW+1:2];
    assign m_cw     = m_sel && m_wr && (m_idx == IW'(CTL_M));
    assign h_cw     = h_sel && h_wr && (h_idx == IW'(CTL_H));
    assign h_data_w = h_sel && h_wr && (h_idx < IW'(NREG));

    // R2
    host_data_flags_mgmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        h_data_w |=> m_stat[$past(h_reg)]);

    // R7
    ring_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (h_cw && h_wdata[0]) |=> m_recv);

    // R6
    ack_unmasks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_cw && m_wdata == 8'h80 && !(h_cw && h_wdata[0])) |=> (!m_recv && !m_mask));

    // R6
    mask_keeps_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_cw && m_wdata == 8'h02 && m_recv) |=> (m_recv && m_mask));

    // R8
    mgmt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_mask && ((m_stat & m_ien) == '0)) |-> !m_irq);

    // R8
    host_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (h_mask && ((h_stat & h_ien) == '0)) |-> !h_irq);

    // R9
    foreign_ctl_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_sel && m_wr && (m_idx == IW'(CTL_H)) && !h_cw) |=> $stable(h_mask));

endmodule

bind byte_mailbox mbox_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .m_sel   (m_sel_i),
    .m_wr    (m_wr_i),
    .m_addr  (m_addr_i),
    .m_wdata (m_wdata_i),
    .h_sel   (h_sel_i),
    .h_wr    (h_wr_i),
    .h_addr  (h_addr_i),
    .h_wdata (h_wdata_i),
    .m_recv  (recv_w[0]),
    .m_mask  (mask_w[0]),
    .h_recv  (recv_w[1]),
    .h_mask  (mask_w[1]),
    .m_stat  (stat_w[0]),
    .m_ien   (ien_w[0]),
    .h_stat  (stat_w[1]),
    .h_ien   (ien_w[1]),
    .m_irq   (m_irq_o),
    .h_irq   (h_irq_o)
);

// File: tb/sim_byte_mailbox.sv
module sim_byte_mailbox;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_sel = 0, m_wr = 0, h_sel = 0, h_wr = 0;
    logic [6:0]  m_addr = '0, h_addr = '0;
    logic [7:0]  m_wdata = '0, h_wdata = '0;
    logic [31:0] m_rdata, h_rdata;
    logic        m_irq, h_irq;

    always #2 clk = ~clk;

    byte_mailbox u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .m_sel_i(m_sel), .m_wr_i(m_wr), .m_addr_i(m_addr), .m_wdata_i(m_wdata),
        .m_rdata_o(m_rdata), .m_irq_o(m_irq),
        .h_sel_i(h_sel), .h_wr_i(h_wr), .h_addr_i(h_addr), .h_wdata_i(h_wdata),
        .h_rdata_o(h_rdata), .h_irq_o(h_irq)
    );

    // reference model, built from the requirements
    logic [7:0]  md [16];
    logic [15:0] mst [2];
    logic [15:0] mie [2];
    logic        mrc [2];
    logic        mmk [2];

    int compared = 0, mismatched = 0;
    bit done = 0;
    logic [31:0] q_exp [$];
    int          q_kind [$];
    string       q_tag [$];

    task automatic m_clear(int s, int a, logic [7:0] v);
        int i = a >> 2;
        if (i == 16 || i == 17) mst[s][(i-16)*8 +: 8] = mst[s][(i-16)*8 +: 8] & ~v;
        if (i == 20 || i == 21) mie[s][(i-20)*8 +: 8] = v;
        if (i == 18 + s) begin
            if (v[7]) mrc[s] = 1'b0;
            mmk[s] = v[1];
        end
    endtask

    task automatic m_set(int s, int a, logic [7:0] v);
        int i = a >> 2;
        if (i < 16) begin
            md[i] = v;
            mst[1-s][i] = 1'b1;
        end
        if (i == 18 + s && v[0]) mrc[1-s] = 1'b1;
    endtask

    function automatic logic [31:0] m_read(int s, int a, bit sel);
        int i = a >> 2;
        logic [7:0] r = '0;
        if (sel) begin
            if (i < 16) r = md[i];
            else if (i == 16 || i == 17) r = mst[s][(i-16)*8 +: 8];
            else if (i == 18) r = {mrc[0], 5'b0, mmk[0], 1'b0};
            else if (i == 19) r = {mrc[1], 5'b0, mmk[1], 1'b0};
            else if (i == 20 || i == 21) r = mie[s][(i-20)*8 +: 8];
        end
        return {24'b0, r};
    endfunction

    function automatic logic m_irqx(int s);
        return (mrc[s] & ~mmk[s]) | (|(mst[s] & mie[s]));
    endfunction

    task automatic idle_ports();
        m_sel = 0; m_wr = 0; h_sel = 0; h_wr = 0;
    endtask

    task automatic drive(int s, bit sel, bit wr, int a, logic [7:0] v);
        if (s == 0) begin m_sel = sel; m_wr = wr; m_addr = a[6:0]; m_wdata = v; end
        else        begin h_sel = sel; h_wr = wr; h_addr = a[6:0]; h_wdata = v; end
    endtask

    task automatic wr(int s, int a, logic [7:0] v);
        @(negedge clk);
        idle_ports();
        drive(s, 1, 1, a, v);
        m_clear(s, a, v);
        m_set(s, a, v);
    endtask

    // both ports write in the same cycle
    task automatic wr2(int am, logic [7:0] vm, int ah, logic [7:0] vh);
        @(negedge clk);
        idle_ports();
        drive(0, 1, 1, am, vm);
        drive(1, 1, 1, ah, vh);
        m_clear(1, ah, vh);
        m_clear(0, am, vm);
        m_set(1, ah, vh);
        m_set(0, am, vm);
    endtask

    task automatic rd(int s, int a, string tag, bit sel = 1);
        @(negedge clk);
        idle_ports();
        drive(s, sel, 0, a, 8'h00);
        q_exp.push_back(m_read(s, a, sel));
        q_kind.push_back(s);
        q_tag.push_back(tag);
    endtask

    task automatic chk_irq(int s, string tag);
        @(negedge clk);
        idle_ports();
        q_exp.push_back({31'b0, m_irqx(s)});
        q_kind.push_back(2 + s);
        q_tag.push_back(tag);
    endtask

    // monitor: compares in the low phase, after the driver has settled
    initial forever begin
        @(negedge clk);
        #1;
        while (q_exp.size() > 0) begin
            logic [31:0] e, a;
            int k;
            string t;
            e = q_exp.pop_front();
            k = q_kind.pop_front();
            t = q_tag.pop_front();
            case (k)
                0: a = m_rdata;
                1: a = h_rdata;
                2: a = {31'b0, m_irq};
                default: a = {31'b0, h_irq};
            endcase
            compared++;
            if (a !== e) begin
                mismatched++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #800000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) md[i] = '0;
        for (int s = 0; s < 2; s++) begin
            mst[s] = '0; mie[s] = '0; mrc[s] = 0; mmk[s] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11: everything clear out of reset
        for (int a = 0; a < 88; a += 4) rd(0, a, "R11 mgmt reset read");
        for (int a = 0; a < 88; a += 4) rd(1, a, "R11 host reset read");
        chk_irq(0, "R11 mgmt irq reset");
        chk_irq(1, "R11 host irq reset");

        // R1 / R2: management fills every register
        for (int i = 0; i < 16; i++) wr(0, 4*i, 8'(i*17 + 3));
        for (int i = 0; i < 16; i++) rd(1, 4*i, "R1 host reads data");
        rd(0, 20, "R1 mgmt reads data");
        rd(1, 'h40, "R2 host flags low");
        rd(1, 'h44, "R2 host flags high");
        rd(0, 'h40, "R2 writer flags untouched");

        // R3: clear on one, zero leaves bits
        wr(1, 'h40, 8'h0F);
        rd(1, 'h40, "R3 partial clear");
        wr(1, 'h44, 8'h00);
        rd(1, 'h44, "R3 zero write keeps");

        // R4 / R8: enable drives interrupt
        wr(1, 'h54, 8'h80);
        rd(1, 'h54, "R4 enable readback");
        chk_irq(1, "R8 host irq from flag");
        wr(1, 'h44, 8'h80);
        chk_irq(1, "R8 host irq after clear");
        wr(1, 'h50, 8'hA5);
        rd(1, 'h50, "R4 enable low bank");
        rd(0, 'h50, "R4 mgmt enable separate");

        // R5: doorbell from host
        wr(1, 'h4C, 8'h01);
        rd(0, 'h48, "R5 mgmt recv raised");
        rd(1, 'h4C, "R5 send reads zero");
        chk_irq(0, "R8 mgmt irq on ring");

        // R6: mask then acknowledge
        wr(0, 'h48, 8'h02);
        rd(0, 'h48, "R6 mask keeps flag");
        chk_irq(0, "R6 masked irq low");
        wr(0, 'h48, 8'h80);
        rd(0, 'h48, "R6 ack clears and unmasks");
        chk_irq(0, "R6 irq after ack");

        // R9: foreign control write ignored, own ring works
        wr(0, 'h4C, 8'h03);
        rd(1, 'h4C, "R9 foreign write ignored");
        chk_irq(1, "R9 host irq unchanged");
        wr(0, 'h48, 8'h01);
        rd(1, 'h4C, "R9 host recv via own write");
        rd(0, 'h4C, "R9 mgmt reads host ctl");
        chk_irq(1, "R8 host irq on ring");

        // R7: ring and acknowledge collide
        wr(1, 'h4C, 8'h01);
        wr2('h48, 8'h80, 'h4C, 8'h01);
        rd(0, 'h48, "R7 recv survives clear");
        chk_irq(0, "R7 mgmt irq stays");

        // R10: both write register 3
        wr(0, 'h40, 8'hFF);
        wr(1, 'h40, 8'hFF);
        wr2(12, 8'hAA, 12, 8'h55);
        rd(1, 12, "R10 mgmt byte kept");
        rd(0, 'h40, "R10 mgmt flag set");
        rd(1, 'h40, "R10 host flag set");

        // R3: set beats same-cycle clear
        wr2('h44, 8'hFF, 36, 8'h3C);
        rd(0, 'h44, "R3 set wins over clear");

        // R12: unmapped and deselected
        wr(0, 'h60, 8'hFF);
        wr(1, 'h7C, 8'hFF);
        rd(0, 'h58, "R12 unmapped read");
        rd(1, 'h7C, "R12 unmapped read high");
        rd(0, 0, "R12 deselected read", 0);
        for (int a = 0; a < 88; a += 4) rd(0, a, "R12 state after stray write");
        chk_irq(0, "R12 mgmt irq after stray write");
        chk_irq(1, "R12 host irq after stray write");

        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule